// File: doc/BRIEF.md
# Interrupt Cause to Vector Router

The router takes a wide bus of single-cycle interrupt cause events and folds them onto a 32-bit set of pending interrupt bits. A programmable allocation table holds one byte per cause. Each byte carries a destination index and a valid flag. Software reaches the table through a simple word-addressed register port. Each 32-bit register holds the bytes of four consecutive causes.

A mode input picks how the index is read. With `legacy_mode` low, the index names one of 32 message-signalled vectors, and the matching pending bit is set. With `legacy_mode` high, only the low four index bits are used. They select one of 16 queue bits of a shared cause register, which sit in the low half of the output.

Pending bits are sticky. They stay set until a matching bit is pulsed on the clear input.

Top module: `irq_vector_router`

## Requirements
- R1: After a synchronous reset, every table entry reads zero, so all entries are invalid, and `pend_out` is zero.
- R2: Register address n holds causes 4n to 4n+3. Cause 4n+k occupies bits [8k+7:8k]. `cfg_rdata` shows the register addressed in the previous cycle.
- R3: Within an entry, bits [4:0] are the destination index and bit 7 is the valid flag. Bits [6:5] always read zero and ignore writes.
- R4: Bytes of register 24 above cause 97 (bits [31:16]) read zero. Register addresses 25 to 31 read zero, and writes to them change no entry.
- R5: An event on a cause whose entry is invalid sets no bit of `pend_out`.
- R6: With `legacy_mode` low, an event on a valid cause sets `pend_out[index]` at the next rising clock edge.
- R7: With `legacy_mode` high, an event on a valid cause sets `pend_out[index[3:0]]`, and bits [31:16] are never newly set.
- R8: Events from several causes in one cycle are OR-ed together, whether they share a destination bit or not.
- R9: A pending bit stays set until the matching `pend_clr` bit is high at a clock edge. The bit then reads zero after that edge, and other bits are left alone.
- R10: When a new event and a clear hit the same bit at the same edge, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register word address, for both read and write |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data for the previous cycle's address |
| cause_evt | input | 98 | One event bit per interrupt cause |
| legacy_mode | input | 1 | 1 selects queue-bit mode, 0 selects message-vector mode |
| pend_clr | input | 32 | Per-bit clear of pending bits |
| pend_out | output | 32 | Sticky pending bits |

## Verification
Two situations are hard to reach from the ports. The first is a collision: several causes, including the two entries at the very top of the table, strike one destination in the same cycle as an unrelated cause. The second is a clear that arrives on the same edge as a fresh event. The bench programs overlapping entries and drives all of the colliding event bits and the clear mask at a single falling edge. It then reads `pend_out` at the next falling edge. Aliasing of out-of-range addresses is checked by writing address 27, which shares its low bits with a live register, and then reading that live register back.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int ENTRY_W = 8;
  localparam int REG_W   = 32;
  localparam int PER_REG = REG_W / ENTRY_W;
endpackage

// File: rtl/irq_alloc_table.sv
module irq_alloc_table
  import irq_router_pkg::*;
#(
  parameter int NUM_CAUSES = 98,
  parameter int IDX_W      = 5,
  parameter int ADDR_W     = 5
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             we,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [REG_W-1:0]                 wdata,
  output logic [REG_W-1:0]                 rdata,
  output logic [NUM_CAUSES-1:0]            ent_valid,
  output logic [NUM_CAUSES-1:0][IDX_W-1:0] ent_idx
);
  localparam int NUM_REGS = (NUM_CAUSES + PER_REG - 1) / PER_REG;
  localparam int RSV_W    = ENTRY_W - 1 - IDX_W;

  for (genvar c = 0; c < NUM_CAUSES; c++) begin : g_entry
    localparam int RI = c / PER_REG;
    localparam int BI = c % PER_REG;
    always_ff @(posedge clk) begin
      if (rst) begin
        ent_valid[c] <= 1'b0;
        ent_idx[c]   <= '0;
      end else if (we && addr == ADDR_W'(RI)) begin
        ent_valid[c] <= wdata[ENTRY_W*BI + ENTRY_W - 1];
        ent_idx[c]   <= wdata[ENTRY_W*BI +: IDX_W];
      end
    end
  end

  logic [REG_W-1:0] rd_word;
  always_comb begin
    rd_word = '0;
    for (int c = 0; c < NUM_CAUSES; c++) begin
      if (addr == ADDR_W'(c / PER_REG))
        rd_word[ENTRY_W*(c % PER_REG) +: ENTRY_W] = {ent_valid[c], {RSV_W{1'b0}}, ent_idx[c]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_word;
  end

  // R4: unmapped addresses read back as zero
  a_r4_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (int'(addr) >= NUM_REGS) |=> (rdata == '0));

  // R3: reserved bits of every byte read zero
  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (rdata & 32'h6060_6060) == '0);
endmodule

// File: rtl/irq_cause_decode.sv
module irq_cause_decode #(
  parameter int NUM_CAUSES = 98,
  parameter int IDX_W      = 5,
  parameter int LEG_Q      = 16,
  localparam int NUM_VEC   = 1 << IDX_W
) (
  input  logic [NUM_CAUSES-1:0]            evt,
  input  logic [NUM_CAUSES-1:0]            ent_valid,
  input  logic [NUM_CAUSES-1:0][IDX_W-1:0] ent_idx,
  input  logic                             legacy_mode,
  output logic [NUM_VEC-1:0]               hits
);
  localparam logic [IDX_W-1:0] LEG_MASK = IDX_W'(LEG_Q - 1);

  always_comb begin
    hits = '0;
    for (int c = 0; c < NUM_CAUSES; c++) begin
      if (evt[c] && ent_valid[c]) begin
        if (legacy_mode) hits[ent_idx[c] & LEG_MASK] = 1'b1;
        else             hits[ent_idx[c]]            = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_pending_reg.sv
module irq_pending_reg #(
  parameter int NUM_VEC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_VEC-1:0] hits,
  input  logic [NUM_VEC-1:0] clr,
  output logic [NUM_VEC-1:0] pend
);
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~clr) | hits;
  end

  // R1: reset empties the pending set
  a_r1_reset_clear: assert property (@(posedge clk) rst |=> (pend == '0));

  // R6 / R10: a hit is always captured, even against a clear
  a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend & $past(hits)) == $past(hits)));

  // R9: bits without a clear stay set
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend & $past(pend & ~clr)) == $past(pend & ~clr)));

  // R9: a clear without a hit drops the bit
  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend & $past(clr & ~hits)) == '0));
endmodule

// File: rtl/irq_vector_router.sv
module irq_vector_router
  import irq_router_pkg::*;
#(
  parameter int NUM_CAUSES = 98,
  parameter int IDX_W      = 5,
  parameter int LEG_Q      = 16,
  localparam int NUM_VEC   = 1 << IDX_W,
  localparam int NUM_REGS  = (NUM_CAUSES + PER_REG - 1) / PER_REG,
  localparam int ADDR_W    = $clog2(NUM_REGS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [ADDR_W-1:0]     cfg_addr,
  input  logic [REG_W-1:0]      cfg_wdata,
  output logic [REG_W-1:0]      cfg_rdata,
  input  logic [NUM_CAUSES-1:0] cause_evt,
  input  logic                  legacy_mode,
  input  logic [NUM_VEC-1:0]    pend_clr,
  output logic [NUM_VEC-1:0]    pend_out
);
  logic [NUM_CAUSES-1:0]            ent_valid;
  logic [NUM_CAUSES-1:0][IDX_W-1:0] ent_idx;
  logic [NUM_VEC-1:0]               hits;

  irq_alloc_table #(
    .NUM_CAUSES(NUM_CAUSES), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
  ) u_table (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .ent_valid(ent_valid), .ent_idx(ent_idx)
  );

  irq_cause_decode #(
    .NUM_CAUSES(NUM_CAUSES), .IDX_W(IDX_W), .LEG_Q(LEG_Q)
  ) u_decode (
    .evt(cause_evt), .ent_valid(ent_valid), .ent_idx(ent_idx),
    .legacy_mode(legacy_mode), .hits(hits)
  );

  irq_pending_reg #(.NUM_VEC(NUM_VEC)) u_pend (
    .clk(clk), .rst(rst), .hits(hits), .clr(pend_clr), .pend(pend_out)
  );

  // R7: queue-bit mode never raises the upper vector bits
  a_r7_legacy_low_only: assert property (@(posedge clk) disable iff (rst)
    legacy_mode |-> ((hits >> LEG_Q) == '0));

  // R5: no event means no new pending bit
  a_r5_quiet_no_set: assert property (@(posedge clk) disable iff (rst)
    (cause_evt == '0) |=> ((pend_out & ~$past(pend_out)) == '0));
endmodule

// File: tb/irq_vector_router_test.sv
module irq_vector_router_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [4:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic [97:0] cause_evt;
  logic        legacy_mode;
  logic [31:0] pend_clr;
  logic [31:0] pend_out;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  irq_vector_router uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cause_evt(cause_evt),
    .legacy_mode(legacy_mode), .pend_clr(pend_clr), .pend_out(pend_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); cfg_addr = a;
    @(negedge clk); d = cfg_rdata;
  endtask

  task automatic pulse(input logic [97:0] ev, input logic [31:0] clr);
    @(negedge clk); cause_evt = ev; pend_clr = clr;
    @(negedge clk); cause_evt = '0; pend_clr = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 pend_out", pend_out, 32'h0);
    rd(5'd0, d);  check("R1 reg0", d, 32'h0);
    rd(5'd24, d); check("R1 reg24", d, 32'h0);
  endtask

  task automatic t_layout;
    logic [31:0] d;
    wr(5'd3, 32'h9FE5_4183);
    rd(5'd3, d); check("R2 R3 reg3 packing/reserved", d, 32'h9F85_0183);
    wr(5'd24, 32'hFFFF_FFFF);
    rd(5'd24, d); check("R4 reg24 upper bytes", d, 32'h0000_9F9F);
    wr(5'd27, 32'hFFFF_FFFF);
    rd(5'd27, d); check("R4 addr27 reads zero", d, 32'h0);
    rd(5'd3, d);  check("R4 addr27 write no alias", d, 32'h9F85_0183);
    wr(5'd3, 32'h0);
    wr(5'd24, 32'h0);
  endtask

  task automatic t_invalid;
    wr(5'd1, 32'h0000_0007);
    pulse(98'd1 << 4, 32'h0); check("R5 invalid entry ignored", pend_out, 32'h0);
    pulse(98'd1, 32'h0);      check("R5 reset entry ignored", pend_out, 32'h0);
  endtask

  task automatic t_message;
    legacy_mode = 1'b0;
    wr(5'd1, 32'h0000_9F87);
    pulse(98'd1 << 4, 32'h0); check("R6 cause4 to vec7", pend_out, 32'h0000_0080);
    pulse(98'd1 << 5, 32'h0); check("R6 cause5 to vec31", pend_out, 32'h8000_0080);
    pulse('0, 32'hFFFF_FFFF); check("R9 clear all", pend_out, 32'h0);
  endtask

  task automatic t_legacy;
    legacy_mode = 1'b1;
    pulse(98'd1 << 5, 32'h0); check("R7 idx31 to queue bit15", pend_out, 32'h0000_8000);
    pulse(98'd1 << 4, 32'h0); check("R7 idx7 to queue bit7", pend_out, 32'h0000_8080);
    pulse('0, 32'hFFFF_FFFF);
    legacy_mode = 1'b0;
  endtask

  task automatic t_shared;
    wr(5'd24, 32'h0000_8A8A);
    wr(5'd0, 32'h0000_008A);
    pulse((98'd1 << 97) | (98'd1 << 96) | (98'd1 << 5) | 98'd1, 32'h0);
    check("R8 shared and distinct OR", pend_out, 32'h8000_0400);
    pulse('0, 32'h0000_0400);
    check("R9 partial clear", pend_out, 32'h8000_0000);
    repeat (3) @(negedge clk);
    check("R9 sticky idle", pend_out, 32'h8000_0000);
  endtask

  task automatic t_collide;
    pulse(98'd1 << 5, 32'h8000_0000);
    check("R10 set beats clear", pend_out, 32'h8000_0000);
    pulse('0, 32'h8000_0000);
    check("R9 clear after collision", pend_out, 32'h0);
    wr(5'd1, 32'h0000_1F87);
    pulse(98'd1 << 5, 32'h0);
    check("R5 invalidated entry ignored", pend_out, 32'h0);
  endtask

  initial begin
    #(200000 * 10);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    cause_evt = '0; legacy_mode = 1'b0; pend_clr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_layout;
    t_invalid;
    t_message;
    t_legacy;
    t_shared;
    t_collide;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule